// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is a write-only slave on a three-wire control bus made of a bus clock, a mode line and a data line. A host first sends an address byte with the mode line low. That byte names the device and picks one of two register banks. While the mode line is high, the host then sends any number of data bytes. The top two bits of each data byte pick a register inside the selected bank, and the remaining bits carry the new value. The registers drive a configuration word that sets up the rest of an audio path: the system clock ratio, the serial sample format, a DC-removal filter enable, a volume code, de-emphasis, mute, and the power enables of the converters.

All three bus lines are asynchronous to the local clock. Each line is brought into the local domain through a two-flop synchronizer. A rising edge of the bus clock is detected in the local domain, so the local clock must run several times faster than the bus clock. The host must write the registers after power-up, and the active-low asynchronous reset puts every register into a known state.

Top module: `ctl3w_port`

## Requirements
- R1: Bits are sampled on rising edges of the bus clock. The first bit received is bit 0 of the byte, and a byte is complete after 8 rising edges.
- R2: A byte received with the mode line low is an address byte. Its bits 7..2 (bit 7 is the MSB) are compared with the device address 6'b000101. An address byte never changes a configuration output.
- R3: In a matching address byte, bits 1..0 = 2'b00 select the DATA bank and 2'b10 select the STATUS bank. The codes 2'b01 and 2'b11 select no bank, and data bytes that follow them change nothing.
- R4: An address byte whose bits 7..2 differ from 6'b000101 deselects the port. Data bytes that follow it change no output.
- R5: A bank selection stays in force for any number of data bytes, and only the next address byte changes it.
- R6: A register changes only after the eighth bit of a byte. A change of the mode line part-way through a byte discards the bits already received, and counting restarts at bit 0.
- R7: DATA bank, decoded by byte bits 7..6. Code 00 writes the volume output from bits 5..0. Code 10 writes de-emphasis from bits 4..3 and mute from bit 2. Code 11 writes the ADC enable from bit 1 and the DAC enable from bit 0. Code 01 writes nothing.
- R8: STATUS bank. With bits 7..6 = 00, the clock select is taken from bits 5..4 (00 = 512fs, 01 = 384fs, 10 = 256fs), the format code from bits 3..1 and the DC filter enable from bit 0. A STATUS byte with any other value in bits 7..6 writes nothing, and a STATUS byte never touches a DATA-bank output.
- R9: While rst_ni is low, every output is 0 and no bank is selected.
- R10: A written value appears on the outputs no later than 6 local clock cycles after the eighth rising edge of the bus clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock, several times faster than the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_clk_i | input | 1 | Serial bus clock, idle high, asynchronous |
| bus_mode_i | input | 1 | Low for an address byte, high for data bytes |
| bus_dat_i | input | 1 | Serial data, LSB first |
| clk_sel_o | output | 2 | System clock ratio code |
| fmt_o | output | 3 | Serial sample format code |
| dc_en_o | output | 1 | DC-removal filter enable |
| vol_o | output | 6 | Volume attenuation code |
| deemph_o | output | 2 | De-emphasis select |
| mute_o | output | 1 | Playback mute |
| adc_en_o | output | 1 | ADC power enable |
| dac_en_o | output | 1 | DAC power enable |

## Verification
The hardest case to reach from the ports is a byte cut short by a change of the mode line. If the partial bits were kept, every later byte would be shifted by that many bits. The stimulus sends five data bits, lowers the mode line and sends a full address byte, then sends a data byte that is checked for exact alignment. A seeded random mix of matching addresses, foreign addresses, unused bank codes and arbitrary data bytes then exercises the sticky bank state against a bench model.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    BANK_NONE = 2'd0,
    BANK_DATA = 2'd1,
    BANK_STAT = 2'd2
  } bank_e;

  // address byte bank codes
  localparam logic [1:0] SEL_DATA = 2'b00;
  localparam logic [1:0] SEL_STAT = 2'b10;

  // DATA bank register codes (byte bits 7..6)
  localparam logic [1:0] DREG_VOL = 2'b00;
  localparam logic [1:0] DREG_DEM = 2'b10;
  localparam logic [1:0] DREG_PWR = 2'b11;
  localparam logic [1:0] SREG_SYS = 2'b00;

  typedef struct packed {
    logic [1:0] clk_sel;
    logic [2:0] fmt;
    logic       dc_en;
    logic [5:0] vol;
    logic [1:0] deemph;
    logic       mute;
    logic       adc_en;
    logic       dac_en;
  } cfg_t;

  localparam cfg_t CFG_RST = '0;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] rst_val_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= rst_val_i;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ctl3w_shifter.sv
module ctl3w_shifter
  import ctl3w_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              smode_i,
  input  logic              sdat_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              mode_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              clk_q, mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sr_q;
  logic              rise, mode_chg;
  logic [BYTE_W-1:0] sr_nxt;

  assign rise     = sclk_i & ~clk_q;
  assign mode_chg = smode_i ^ mode_q;
  assign sr_nxt   = {sdat_i, sr_q[BYTE_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q      <= 1'b1;  // bus clock idles high
      mode_q     <= 1'b1;
      cnt_q      <= '0;
      sr_q       <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      mode_o     <= 1'b1;
    end else begin
      clk_q      <= sclk_i;
      mode_q     <= smode_i;
      byte_vld_o <= 1'b0;
      if (mode_chg) begin
        // mode change drops a partial byte
        cnt_q <= '0;
      end else if (rise) begin
        sr_q <= sr_nxt;
        if (cnt_q == LAST_BIT) begin
          cnt_q      <= '0;
          byte_vld_o <= 1'b1;
          byte_o     <= sr_nxt;
          mode_o     <= smode_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ctl3w_decode.sv
module ctl3w_decode
  import ctl3w_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR = 6'b000101
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              mode_i,
  output bank_e             bank_o,
  output cfg_t              cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o <= BANK_NONE;
      cfg_o  <= CFG_RST;
    end else if (byte_vld_i) begin
      if (!mode_i) begin
        if (byte_i[7:2] != DEV_ADDR) begin
          bank_o <= BANK_NONE;
        end else begin
          case (byte_i[1:0])
            SEL_DATA: bank_o <= BANK_DATA;
            SEL_STAT: bank_o <= BANK_STAT;
            default:  bank_o <= BANK_NONE;
          endcase
        end
      end else begin
        case (bank_o)
          BANK_DATA: begin
            case (byte_i[7:6])
              DREG_VOL: cfg_o.vol <= byte_i[5:0];
              DREG_DEM: begin
                cfg_o.deemph <= byte_i[4:3];
                cfg_o.mute   <= byte_i[2];
              end
              DREG_PWR: begin
                cfg_o.adc_en <= byte_i[1];
                cfg_o.dac_en <= byte_i[0];
              end
              default: ;
            endcase
          end
          BANK_STAT: begin
            if (byte_i[7:6] == SREG_SYS) begin
              cfg_o.clk_sel <= byte_i[5:4];
              cfg_o.fmt     <= byte_i[3:1];
              cfg_o.dc_en   <= byte_i[0];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctl3w_port.sv
module ctl3w_port
  import ctl3w_pkg::*;
#(
  parameter logic [5:0]  DEV_ADDR    = 6'b000101,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_clk_i,
  input  logic       bus_mode_i,
  input  logic       bus_dat_i,
  output logic [1:0] clk_sel_o,
  output logic [2:0] fmt_o,
  output logic       dc_en_o,
  output logic [5:0] vol_o,
  output logic [1:0] deemph_o,
  output logic       mute_o,
  output logic       adc_en_o,
  output logic       dac_en_o
);
  logic [2:0]        bus_sync;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_q;
  logic              byte_mode;
  bank_e             bank;
  cfg_t              cfg;

  // order: {clk, mode, data}; clock and mode idle high
  ctl3w_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_val_i (3'b110),
    .d_i       ({bus_clk_i, bus_mode_i, bus_dat_i}),
    .q_o       (bus_sync)
  );

  ctl3w_shifter i_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (bus_sync[2]),
    .smode_i    (bus_sync[1]),
    .sdat_i     (bus_sync[0]),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_q),
    .mode_o     (byte_mode)
  );

  ctl3w_decode #(.DEV_ADDR(DEV_ADDR)) i_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_vld_i (byte_vld),
    .byte_i     (byte_q),
    .mode_i     (byte_mode),
    .bank_o     (bank),
    .cfg_o      (cfg)
  );

  assign clk_sel_o = cfg.clk_sel;
  assign fmt_o     = cfg.fmt;
  assign dc_en_o   = cfg.dc_en;
  assign vol_o     = cfg.vol;
  assign deemph_o  = cfg.deemph;
  assign mute_o    = cfg.mute;
  assign adc_en_o  = cfg.adc_en;
  assign dac_en_o  = cfg.dac_en;
endmodule

// File: rtl/ctl3w_checker.sv
module ctl3w_checker
  import ctl3w_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_vld_i,
  input logic              mode_i,
  input logic [BYTE_W-1:0] byte_i,
  input bank_e             bank_i,
  input cfg_t              cfg_i
);
  AST_VLD_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i |=> !byte_vld_i); // R1

  AST_ADDR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !mode_i) |=> $stable(cfg_i)); // R2

  AST_NOSEL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && mode_i && bank_i == BANK_NONE) |=> $stable(cfg_i)); // R4

  AST_BANK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && mode_i) |=> $stable(bank_i)); // R5

  AST_HOLD_MID_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_i |=> $stable(cfg_i)); // R6

  AST_DATA_UNUSED_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && mode_i && bank_i == BANK_DATA && byte_i[7:6] == 2'b01)
      |=> $stable(cfg_i)); // R7

  AST_STATUS_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && mode_i && bank_i == BANK_STAT)
      |=> ($stable(cfg_i.vol) && $stable(cfg_i.deemph) && $stable(cfg_i.mute)
           && $stable(cfg_i.adc_en) && $stable(cfg_i.dac_en))); // R8

  AST_RESET_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (cfg_i == CFG_RST && bank_i == BANK_NONE)); // R9
endmodule

bind ctl3w_port ctl3w_checker i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .byte_vld_i (byte_vld),
  .mode_i     (byte_mode),
  .byte_i     (byte_q),
  .bank_i     (bank),
  .cfg_i      (cfg)
);

// File: tb/test_ctl3w_port.sv
module test_ctl3w_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam logic [7:0] A_DATA = 8'b000101_00;
  localparam logic [7:0] A_STAT = 8'b000101_10;

  logic clk = 1'b0;
  logic rst_ni;
  logic bclk, bmode, bdat;
  logic [1:0] clk_sel_o, deemph_o;
  logic [2:0] fmt_o;
  logic [5:0] vol_o;
  logic dc_en_o, mute_o, adc_en_o, dac_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  int         m_bank;  // 0 none, 1 data, 2 status
  logic [1:0] m_clk_sel, m_deemph;
  logic [2:0] m_fmt;
  logic [5:0] m_vol;
  logic       m_dc, m_mute, m_adc, m_dac;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl3w_port i_ctl3w_port (
    .clk_i(clk), .rst_ni(rst_ni),
    .bus_clk_i(bclk), .bus_mode_i(bmode), .bus_dat_i(bdat),
    .clk_sel_o(clk_sel_o), .fmt_o(fmt_o), .dc_en_o(dc_en_o), .vol_o(vol_o),
    .deemph_o(deemph_o), .mute_o(mute_o), .adc_en_o(adc_en_o), .dac_en_o(dac_en_o)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic model_reset();
    m_bank = 0; m_clk_sel = 0; m_deemph = 0; m_fmt = 0; m_vol = 0;
    m_dc = 0; m_mute = 0; m_adc = 0; m_dac = 0;
  endtask

  task automatic model_byte(input bit m, input logic [7:0] v);
    if (!m) begin
      if (v[7:2] == 6'b000101 && v[1:0] == 2'b00)      m_bank = 1;
      else if (v[7:2] == 6'b000101 && v[1:0] == 2'b10) m_bank = 2;
      else                                             m_bank = 0;
    end else if (m_bank == 1) begin
      if (v[7:6] == 2'b00) m_vol = v[5:0];
      else if (v[7:6] == 2'b10) begin m_deemph = v[4:3]; m_mute = v[2]; end
      else if (v[7:6] == 2'b11) begin m_adc = v[1]; m_dac = v[0]; end
    end else if (m_bank == 2 && v[7:6] == 2'b00) begin
      m_clk_sel = v[5:4]; m_fmt = v[3:1]; m_dc = v[0];
    end
  endtask

  task automatic set_mode(input bit m);
    if (bmode != m) begin
      bmode = m;
      wait_cyc(HALF);
    end
  endtask

  task automatic send_bits(input bit m, input logic [7:0] v, input int nbits);
    set_mode(m);
    for (int i = 0; i < nbits; i++) begin
      bclk = 1'b0; bdat = v[i];
      wait_cyc(HALF);
      bclk = 1'b1;
      wait_cyc(HALF);
    end
  endtask

  // full byte; outputs sampled 6 cycles after the eighth rising edge (R10)
  task automatic send_byte(input bit m, input logic [7:0] v);
    send_bits(m, v, 8);
    wait_cyc(6 - HALF);
    model_byte(m, v);
  endtask

  task automatic check_cfg(input string req);
    logic [16:0] act, exp;
    act = {clk_sel_o, fmt_o, dc_en_o, vol_o, deemph_o, mute_o, adc_en_o, dac_en_o};
    exp = {m_clk_sel, m_fmt, m_dc, m_vol, m_deemph, m_mute, m_adc, m_dac};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 1'b0; bclk = 1'b1; bmode = 1'b1; bdat = 1'b0;
    model_reset();
    wait_cyc(5);
    check_cfg("R9 outputs during reset");
    rst_ni = 1'b1;
    wait_cyc(3);
    check_cfg("R9 state after reset");
    send_byte(1, 8'h2A);
    check_cfg("R9 no bank selected after reset");

    send_byte(0, A_DATA);
    check_cfg("R2 address byte writes nothing");
    send_byte(1, 8'h2A);
    check_cfg("R7 volume write");
    send_byte(1, 8'b10_0_10_1_00);
    check_cfg("R7 de-emphasis and mute");
    send_byte(1, 8'hC2);
    check_cfg("R7 power enables");
    send_byte(1, 8'h7F);
    check_cfg("R7 unused register code 01");
    send_byte(1, 8'h01);
    check_cfg("R1 LSB first volume 01");
    send_byte(1, 8'h20);
    check_cfg("R1 LSB first volume 20");
    send_byte(1, 8'h15);
    check_cfg("R5 bank sticky across bytes");

    send_byte(0, A_STAT);
    send_byte(1, 8'b00_10_101_1);
    check_cfg("R8 status write");
    send_byte(1, 8'h8F);
    check_cfg("R8 status non-zero top bits ignored");
    send_byte(1, 8'h40);
    check_cfg("R8 status code 01 ignored");

    send_byte(0, 8'b000101_01);
    send_byte(1, 8'h05);
    check_cfg("R3 bank code 01 selects nothing");
    send_byte(0, 8'b000101_11);
    send_byte(1, 8'h3C);
    check_cfg("R3 bank code 11 selects nothing");

    send_byte(0, A_DATA);
    send_byte(0, 8'b000111_00);
    send_byte(1, 8'h33);
    check_cfg("R4 foreign address deselects");
    send_byte(0, 8'b100101_00);
    send_byte(1, 8'h0F);
    check_cfg("R4 address differing in MSB");

    send_byte(0, A_DATA);
    send_bits(1, 8'h3F, 5);
    wait_cyc(6);
    check_cfg("R6 no commit before eighth bit");
    send_byte(0, A_DATA);
    send_byte(1, 8'h0A);
    check_cfg("R6 partial byte discarded");

    for (int n = 0; n < 300; n++) begin
      logic [31:0] r;
      logic [7:0]  v;
      r = $urandom;
      if (r[1:0] == 2'b00) begin
        v[7:2] = r[2] ? 6'b000101 : r[13:8];
        v[1:0] = r[5:4];
        send_byte(0, v);
        check_cfg("R2/R3/R4 random address");
      end else begin
        v = r[23:16];
        send_byte(1, v);
        check_cfg("R5/R7/R8 random data");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule